// File: doc/BRIEF.md
# Serial Lane Mapping and Polarity Unit

This block sits between a display link's protocol logic and a set of physical differential lanes. It places one logical clock lane and up to two logical data lanes onto any of the physical lanes. Each logical lane can also have its line polarity swapped. Outgoing bytes are dealt across the active data lanes in arrival order. The low-power receive signal is read back from whichever physical lane currently carries data lane 1.

Software writes a lane setting into a shadow register. The setting is not used at once. It moves into the active register only after the interface enable and the low-power clock enable go through a fixed handshake. A shadow setting in which two lanes claim the same position, or in which a required lane has no position, is flagged and never adopted. Both the shadow and the active setting can be read back at the ports.

Top module: `lane_map_unit`

## Requirements
- R1: A setting word is 9 bits: [1:0] clock-lane position, [2] clock-lane polarity, [4:3] data-lane-1 position, [5] data-lane-1 polarity, [7:6] data-lane-2 position, [8] data-lane-2 polarity. Position k (1..3) selects physical lane k-1, which is bit k-1 of every per-lane port. After a synchronous reset, both shadow and active hold 9'h011 (clock on position 1, data lane 1 on position 2, data lane 2 off, no swaps), and all lane outputs, `lp_rx` and `cfg_err` are 0.
- R2: `cfg_wr` loads `cfg_wdata` into the shadow on a clock edge only while `lp_clk_en` is low. While `lp_clk_en` is high, the write is ignored.
- R3: `cfg_err` is 1 in the cycle after the shadow takes a setting with any of these faults: the clock or data-lane-1 position is 0, two logical lanes share a position, or a position exceeds the lane count. Otherwise `cfg_err` is 0.
- R4: The active setting takes the shadow value on the clock edge that completes this handshake: `if_en` rises while `lp_clk_en` is low, then `if_en` falls, then `lp_clk_en` rises while `if_en` is low, then `if_en` rises while `lp_clk_en` is still high.
- R5: Any other order of those events leaves the active setting unchanged. A flagged shadow is never adopted, even when the handshake completes.
- R6: With data lane 2 at position 0, each byte accepted (`tx_valid` and `if_en` high) appears on the data-lane-1 physical lane on the next cycle, with that lane's `phy_vld` bit set.
- R7: With data lane 2 active, bytes are paired. The earlier byte of a pair goes to data lane 1 and the later byte to data lane 2. Both appear together on the cycle after the second byte is accepted.
- R8: A set polarity bit presents that lane's byte with every bit inverted.
- R9: `phy_clk_line` carries `clk_lane_in`, XORed with the clock polarity bit, on the clock-lane physical lane. It is 0 on every other lane.
- R10: `lp_rx` is registered and equals the receive input of the data-lane-1 physical lane, XORed with the data-lane-1 polarity bit.
- R11: While `if_en` is low, input bytes are ignored: no `phy_vld` bit rises. A half-filled pair is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Shadow write strobe |
| cfg_wdata | input | 9 | Lane setting to write |
| if_en | input | 1 | Interface enable level |
| lp_clk_en | input | 1 | Low-power clock enable level |
| tx_valid | input | 1 | Byte offered this cycle |
| tx_byte | input | BYTE_W | Outgoing byte |
| clk_lane_in | input | 1 | Logical clock-lane line state |
| phy_lp_rx | input | NUM_PHY | Low-power receive from each physical lane |
| shadow_q | output | 9 | Programmed (shadow) setting |
| active_q | output | 9 | Setting in use |
| cfg_err | output | 1 | Shadow setting is inconsistent |
| phy_vld | output | NUM_PHY | Byte present on each physical lane |
| phy_data | output | NUM_PHY*BYTE_W | Byte per physical lane, lane k at bits k*BYTE_W upward |
| phy_clk_line | output | NUM_PHY | Clock line state per physical lane |
| lp_rx | output | 1 | Low-power receive from data lane 1 |

## Verification
The hardest case to reach is the handshake that adopts a setting. It needs four level changes on two inputs, in order, with nothing else in between. The stimulus runs that order both with a valid and with a flagged shadow. It also runs a near miss in which the low-power clock rises before the interface has been switched off. In each case the bench checks that only the correct order moves the active setting. A second hard case is a pair left half-filled when the interface drops. The bench leaves an odd byte pending, disables the interface, and then checks that the next pair holds only new bytes.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int POS_W = 2;
  localparam int CFG_W = 3 * (POS_W + 1);

  typedef struct packed {
    logic             d2_pol;
    logic [POS_W-1:0] d2_pos;
    logic             d1_pol;
    logic [POS_W-1:0] d1_pos;
    logic             clk_pol;
    logic [POS_W-1:0] clk_pos;
  } lane_cfg_t;

  localparam lane_cfg_t CFG_RESET = 9'h011;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ON1, SQ_OFF, SQ_CLK} seq_t;

  function automatic logic cfg_ok(lane_cfg_t c, int unsigned n_phy);
    logic r;
    r = (c.clk_pos != '0) && (c.d1_pos != '0);
    r = r && (32'(c.clk_pos) <= n_phy) && (32'(c.d1_pos) <= n_phy);
    r = r && (32'(c.d2_pos) <= n_phy);
    r = r && (c.d1_pos != c.clk_pos);
    r = r && ((c.d2_pos == '0) ||
              ((c.d2_pos != c.clk_pos) && (c.d2_pos != c.d1_pos)));
    return r;
  endfunction
endpackage

// File: rtl/lm_cfg_seq.sv
module lm_cfg_seq
  import lm_pkg::*;
#(
  parameter int NUM_PHY = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_wr,
  input  lane_cfg_t cfg_wdata,
  input  logic      if_en,
  input  logic      lp_clk_en,
  output lane_cfg_t shadow_q,
  output lane_cfg_t active_q,
  output logic      cfg_err
);
  seq_t      st_q;
  seq_t      st_d;
  logic      if_q;
  logic      lp_q;
  logic      if_rise;
  logic      if_fall;
  logic      lp_rise;
  logic      adopt;
  lane_cfg_t shadow_d;

  assign if_rise = if_en & ~if_q;
  assign if_fall = ~if_en & if_q;
  assign lp_rise = lp_clk_en & ~lp_q;
  assign shadow_d = (cfg_wr && !lp_clk_en) ? cfg_wdata : shadow_q;

  always_comb begin
    st_d  = st_q;
    adopt = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (if_rise && !lp_clk_en) st_d = SQ_ON1;
      SQ_ON1: begin
        if (lp_rise)      st_d = SQ_IDLE;
        else if (if_fall) st_d = SQ_OFF;
      end
      SQ_OFF: begin
        if (if_rise)      st_d = lp_clk_en ? SQ_IDLE : SQ_ON1;
        else if (lp_rise) st_d = SQ_CLK;
      end
      SQ_CLK: begin
        if (!lp_clk_en) st_d = SQ_IDLE;
        else if (if_rise) begin
          st_d  = SQ_IDLE;
          adopt = ~cfg_err;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      if_q     <= 1'b0;
      lp_q     <= 1'b0;
      shadow_q <= CFG_RESET;
      active_q <= CFG_RESET;
      cfg_err  <= 1'b0;
    end else begin
      st_q     <= st_d;
      if_q     <= if_en;
      lp_q     <= lp_clk_en;
      shadow_q <= shadow_d;
      cfg_err  <= ~cfg_ok(shadow_d, NUM_PHY);
      if (adopt) active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/lm_tx_dist.sv
module lm_tx_dist
  import lm_pkg::*;
#(
  parameter int NUM_PHY = 3,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      if_en,
  input  logic                      tx_valid,
  input  logic [BYTE_W-1:0]         tx_byte,
  input  logic [POS_W-1:0]          d1_pos,
  input  logic                      d1_pol,
  input  logic [POS_W-1:0]          d2_pos,
  input  logic                      d2_pol,
  output logic [NUM_PHY-1:0]        phy_vld,
  output logic [NUM_PHY*BYTE_W-1:0] phy_data
);
  logic              dual;
  logic              take;
  logic              half_q;
  logic [BYTE_W-1:0] hold_q;
  logic              emit1;
  logic              emit2;
  logic [BYTE_W-1:0] lane1_byte;
  logic [BYTE_W-1:0] lane2_byte;

  assign dual       = (d2_pos != '0);
  assign take       = if_en & tx_valid;
  assign emit1      = take & (~dual | half_q);
  assign emit2      = take & dual & half_q;
  assign lane1_byte = (dual ? hold_q : tx_byte) ^ {BYTE_W{d1_pol}};
  assign lane2_byte = tx_byte ^ {BYTE_W{d2_pol}};

  always_ff @(posedge clk) begin
    if (rst || !if_en || !dual) begin
      half_q <= 1'b0;
    end else if (take) begin
      half_q <= ~half_q;
    end
    if (rst) hold_q <= '0;
    else if (take && dual && !half_q) hold_q <= tx_byte;
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_lane
    logic hit1;
    logic hit2;
    assign hit1 = emit1 && (d1_pos == POS_W'(g + 1));
    assign hit2 = emit2 && (d2_pos == POS_W'(g + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        phy_vld[g]                     <= 1'b0;
        phy_data[g*BYTE_W +: BYTE_W]   <= '0;
      end else begin
        phy_vld[g] <= hit1 | hit2;
        if (hit1)      phy_data[g*BYTE_W +: BYTE_W] <= lane1_byte;
        else if (hit2) phy_data[g*BYTE_W +: BYTE_W] <= lane2_byte;
        else           phy_data[g*BYTE_W +: BYTE_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/lm_lane_rx.sv
module lm_lane_rx
  import lm_pkg::*;
#(
  parameter int NUM_PHY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [POS_W-1:0]   clk_pos,
  input  logic               clk_pol,
  input  logic [POS_W-1:0]   d1_pos,
  input  logic               d1_pol,
  input  logic               clk_lane_in,
  input  logic [NUM_PHY-1:0] phy_lp_rx,
  output logic [NUM_PHY-1:0] phy_clk_line,
  output logic               lp_rx
);
  logic rx_pick;

  always_comb begin
    rx_pick = 1'b0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (d1_pos == POS_W'(i + 1)) rx_pick = phy_lp_rx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lp_rx <= 1'b0;
    else     lp_rx <= rx_pick ^ d1_pol;
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_clk
    always_ff @(posedge clk) begin
      if (rst) phy_clk_line[g] <= 1'b0;
      else     phy_clk_line[g] <= (clk_pos == POS_W'(g + 1)) & (clk_lane_in ^ clk_pol);
    end
  end
endmodule

// File: rtl/lane_map_unit.sv
module lane_map_unit
  import lm_pkg::*;
#(
  parameter int NUM_PHY = 3,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [CFG_W-1:0]          cfg_wdata,
  input  logic                      if_en,
  input  logic                      lp_clk_en,
  input  logic                      tx_valid,
  input  logic [BYTE_W-1:0]         tx_byte,
  input  logic                      clk_lane_in,
  input  logic [NUM_PHY-1:0]        phy_lp_rx,
  output logic [CFG_W-1:0]          shadow_q,
  output logic [CFG_W-1:0]          active_q,
  output logic                      cfg_err,
  output logic [NUM_PHY-1:0]        phy_vld,
  output logic [NUM_PHY*BYTE_W-1:0] phy_data,
  output logic [NUM_PHY-1:0]        phy_clk_line,
  output logic                      lp_rx
);
  lane_cfg_t sh_s;
  lane_cfg_t act_s;

  assign shadow_q = sh_s;
  assign active_q = act_s;

  lm_cfg_seq #(.NUM_PHY(NUM_PHY)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (lane_cfg_t'(cfg_wdata)),
    .if_en     (if_en),
    .lp_clk_en (lp_clk_en),
    .shadow_q  (sh_s),
    .active_q  (act_s),
    .cfg_err   (cfg_err)
  );

  lm_tx_dist #(.NUM_PHY(NUM_PHY), .BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .if_en    (if_en),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .d1_pos   (act_s.d1_pos),
    .d1_pol   (act_s.d1_pol),
    .d2_pos   (act_s.d2_pos),
    .d2_pol   (act_s.d2_pol),
    .phy_vld  (phy_vld),
    .phy_data (phy_data)
  );

  lm_lane_rx #(.NUM_PHY(NUM_PHY)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .clk_pos      (act_s.clk_pos),
    .clk_pol      (act_s.clk_pol),
    .d1_pos       (act_s.d1_pos),
    .d1_pol       (act_s.d1_pol),
    .clk_lane_in  (clk_lane_in),
    .phy_lp_rx    (phy_lp_rx),
    .phy_clk_line (phy_clk_line),
    .lp_rx        (lp_rx)
  );
endmodule

// File: rtl/lane_map_unit_chk.sv
module lane_map_unit_chk #(
  parameter int NUM_PHY = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic               if_en,
  input logic               lp_clk_en,
  input logic [8:0]         shadow_q,
  input logic [8:0]         active_q,
  input logic               cfg_err,
  input logic [NUM_PHY-1:0] phy_vld,
  input logic [NUM_PHY-1:0] phy_clk_line
);
  assert_wr_guard_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && lp_clk_en) |=> $stable(shadow_q));

  assert_err_follows_R3: assert property (@(posedge clk) disable iff (rst)
    $stable(shadow_q) |-> $stable(cfg_err));

  assert_adopt_src_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> (active_q == $past(shadow_q) && !$past(cfg_err)));

  assert_adopt_edge_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> ($past(if_en) && !$past(if_en, 2) && $past(lp_clk_en)));

  assert_single_lane_R6: assert property (@(posedge clk) disable iff (rst)
    ((active_q[7:6] == 2'd0) && ($past(active_q[7:6]) == 2'd0)) |-> ($countones(phy_vld) <= 1));

  assert_clk_one_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phy_clk_line));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(if_en) |-> (phy_vld == '0));
endmodule

bind lane_map_unit lane_map_unit_chk #(.NUM_PHY(NUM_PHY)) u_chk (.*);

// File: tb/sim_lane_map_unit.sv
module sim_lane_map_unit;
  localparam int NP = 3;
  localparam int BW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst = 1'b1;
  logic           cfg_wr = 1'b0;
  logic [8:0]     cfg_wdata = '0;
  logic           if_en = 1'b0;
  logic           lp_clk_en = 1'b0;
  logic           tx_valid = 1'b0;
  logic [BW-1:0]  tx_byte = '0;
  logic           clk_lane_in = 1'b0;
  logic [NP-1:0]  phy_lp_rx = '0;
  logic [8:0]     shadow_q;
  logic [8:0]     active_q;
  logic           cfg_err;
  logic [NP-1:0]  phy_vld;
  logic [NP*BW-1:0] phy_data;
  logic [NP-1:0]  phy_clk_line;
  logic           lp_rx;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  lane_map_unit #(.NUM_PHY(NP), .BYTE_W(BW)) u0 (.*);

  // reference model state
  logic [8:0]      m_sh = 9'h011;
  logic [8:0]      m_act = 9'h011;
  logic            m_err = 1'b0;
  int              m_st = 0;
  logic            p_if = 1'b0;
  logic            p_lp = 1'b0;
  logic [BW-1:0]   pend[$];
  logic [NP-1:0]   e_vld = '0;
  logic [NP*BW-1:0] e_data = '0;
  logic [NP-1:0]   e_clk = '0;
  logic            e_rx = 1'b0;

  function automatic bit good_cfg(logic [8:0] c);
    int cp = int'(c[1:0]);
    int a  = int'(c[4:3]);
    int b  = int'(c[7:6]);
    if (cp < 1 || cp > NP || a < 1 || a > NP || b > NP) return 0;
    if (a == cp) return 0;
    if (b != 0 && (b == cp || b == a)) return 0;
    return 1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int cp;
    int a;
    int b;
    bit irise;
    bit ifall;
    bit lrise;
    logic [BW-1:0] first;
    logic [BW-1:0] second;
    started = 1;
    if (rst) begin
      m_sh = 9'h011; m_act = 9'h011; m_err = 0; m_st = 0;
      p_if = 0; p_lp = 0; pend.delete();
      e_vld = '0; e_data = '0; e_clk = '0; e_rx = 0;
    end else begin
      cp = int'(m_act[1:0]);
      a  = int'(m_act[4:3]);
      b  = int'(m_act[7:6]);
      e_vld = '0; e_data = '0; e_clk = '0;
      if (if_en && tx_valid) begin
        if (b == 0) begin
          e_vld[a-1] = 1'b1;
          e_data[(a-1)*BW +: BW] = tx_byte ^ {BW{m_act[5]}};
        end else begin
          pend.push_back(tx_byte);
          if (pend.size() == 2) begin
            first  = pend.pop_front();
            second = pend.pop_front();
            e_vld[a-1] = 1'b1;
            e_vld[b-1] = 1'b1;
            e_data[(a-1)*BW +: BW] = first ^ {BW{m_act[5]}};
            e_data[(b-1)*BW +: BW] = second ^ {BW{m_act[8]}};
          end
        end
      end
      if (!if_en) pend.delete();
      e_clk[cp-1] = clk_lane_in ^ m_act[2];
      e_rx = phy_lp_rx[a-1] ^ m_act[5];
      irise = if_en && !p_if;
      ifall = !if_en && p_if;
      lrise = lp_clk_en && !p_lp;
      case (m_st)
        0: if (irise && !lp_clk_en) m_st = 1;
        1: if (lrise) m_st = 0; else if (ifall) m_st = 2;
        2: if (irise) m_st = lp_clk_en ? 0 : 1; else if (lrise) m_st = 3;
        default: begin
          if (!lp_clk_en) m_st = 0;
          else if (irise) begin
            if (!m_err) m_act = m_sh;
            m_st = 0;
          end
        end
      endcase
      if (cfg_wr && !lp_clk_en) m_sh = cfg_wdata;
      m_err = !good_cfg(m_sh);
      p_if = if_en;
      p_lp = lp_clk_en;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 shadow_q", 32'(shadow_q), 32'(m_sh));
      chk("R4 active_q", 32'(active_q), 32'(m_act));
      chk("R3 cfg_err", 32'(cfg_err), 32'(m_err));
      chk("R7 phy_vld", 32'(phy_vld), 32'(e_vld));
      chk("R8 phy_data", 32'(phy_data), 32'(e_data));
      chk("R9 phy_clk_line", 32'(phy_clk_line), 32'(e_clk));
      chk("R10 lp_rx", 32'(lp_rx), 32'(e_rx));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic traffic(int n);
    for (int k = 0; k < n; k++) begin
      tx_valid    = 1'($urandom_range(0, 1));
      tx_byte     = 8'($urandom);
      clk_lane_in = 1'($urandom_range(0, 1));
      phy_lp_rx   = 3'($urandom);
      cyc(1);
    end
    tx_valid = 1'b0;
  endtask

  task automatic write_cfg(logic [8:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic adopt_seq();
    if_en = 1'b1; cyc(2);
    if_en = 1'b0; cyc(2);
    lp_clk_en = 1'b1; cyc(2);
    if_en = 1'b1; cyc(2);
  endtask

  initial begin
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset shadow", 32'(shadow_q), 32'h011);
    chk("R1 reset active", 32'(active_q), 32'h011);
    chk("R1 reset vld", 32'(phy_vld), 32'h0);
    chk("R1 reset err", 32'(cfg_err), 32'h0);

    // single-lane traffic on default mapping (R6)
    if_en = 1'b1;
    traffic(40);

    // R11: interface off, byte offered
    if_en = 1'b0; tx_valid = 1'b1; tx_byte = 8'hAA;
    cyc(1);
    tx_valid = 1'b0;
    cyc(1);
    chk("R11 vld while disabled", 32'(phy_vld), 32'h0);

    // R2: write while low-power clock on
    lp_clk_en = 1'b1;
    write_cfg(9'h0F3);
    cyc(1);
    chk("R2 write blocked", 32'(shadow_q), 32'h011);
    lp_clk_en = 1'b0;
    cyc(1);

    // R3 and R5: duplicate position, handshake completes, not adopted
    write_cfg(9'h009);
    chk("R3 dup flagged", 32'(cfg_err), 32'h1);
    adopt_seq();
    chk("R5 flagged not adopted", 32'(active_q), 32'h011);
    lp_clk_en = 1'b0; if_en = 1'b0; cyc(2);

    // valid dual setting, wrong order first (R5)
    write_cfg(9'h18F);
    chk("R3 valid clear", 32'(cfg_err), 32'h0);
    if_en = 1'b1; cyc(2);
    lp_clk_en = 1'b1; cyc(2);
    if_en = 1'b0; cyc(2);
    if_en = 1'b1; cyc(2);
    chk("R5 wrong order", 32'(active_q), 32'h011);
    lp_clk_en = 1'b0; if_en = 1'b0; cyc(2);
    adopt_seq();
    chk("R4 adopted", 32'(active_q), 32'h18F);

    // R7 pair ordering with R8 polarity on lane 2
    tx_valid = 1'b1; tx_byte = 8'h3C; cyc(1);
    tx_byte = 8'h5A; cyc(1);
    tx_valid = 1'b0;
    chk("R7 pair vld", 32'(phy_vld), 32'h3);
    chk("R7 first byte lane", 32'(phy_data[7:0]), 32'h3C);
    chk("R8 second byte inverted", 32'(phy_data[15:8]), 32'hA5);

    // R9 clock lane on position 3 with swap
    clk_lane_in = 1'b1; cyc(1);
    chk("R9 clk swapped high", 32'(phy_clk_line), 32'h0);
    clk_lane_in = 1'b0; cyc(1);
    chk("R9 clk swapped low", 32'(phy_clk_line), 32'h4);

    // R10 receive from position 1
    phy_lp_rx = 3'b001; cyc(1);
    chk("R10 rx high", 32'(lp_rx), 32'h1);
    phy_lp_rx = 3'b110; cyc(1);
    chk("R10 rx low", 32'(lp_rx), 32'h0);

    traffic(60);

    // R11: half pair dropped
    tx_valid = 1'b1; tx_byte = 8'h11; cyc(1);
    tx_valid = 1'b0; if_en = 1'b0; cyc(1);
    if_en = 1'b1;
    tx_valid = 1'b1; tx_byte = 8'h22; cyc(1);
    tx_byte = 8'h33; cyc(1);
    tx_valid = 1'b0;
    chk("R11 stale byte dropped", 32'(phy_data[7:0]), 32'h22);

    // single lane on position 3 with swap
    lp_clk_en = 1'b0; if_en = 1'b0; cyc(2);
    write_cfg(9'h03A);
    adopt_seq();
    chk("R4 second adopt", 32'(active_q), 32'h03A);
    tx_valid = 1'b1; tx_byte = 8'h0F; cyc(1);
    tx_valid = 1'b0;
    chk("R6 single lane vld", 32'(phy_vld), 32'h4);
    chk("R8 single inverted", 32'(phy_data[23:16]), 32'hF0);

    traffic(80);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule